// File: doc/BRIEF.md
# Bit-Test Branch Resolver

This block sits at the decode/execute boundary of a 64-bit core. Each cycle it takes one 32-bit instruction word, the fetch PC of that word, the 64-bit value already read from the word's source register, and a flag saying whether the word occupies a branch delay slot. It recognises the four conditional branches that test a single register bit. For each one it decides whether the branch is taken and computes the branch target.

The tested bit position is six bits wide. Its top bit comes from the opcode itself and its low five bits come from the field that would normally name a second register. One opcode family can therefore reach any of the 64 bits. One opcode bit sets the polarity: branch on a set bit or on a clear bit. All results are registered, so decision and target leave the block together one cycle after the word was presented. A recognised branch found in a delay slot is refused with a reserved-instruction strobe instead of a branch.

Top module: `bitbr_resolver`

## Requirements
- R1: Every output is registered and reflects the inputs presented one clock earlier; while `rst_n` is low, `br_valid`, `br_taken`, `slot_follows` and `ri_excp` are 0 and `br_target` is 0.
- R2: A word is recognised only when `instr[31:30]` is `2'b11` and `instr[27:26]` is `2'b10`, i.e. one of the primary opcodes `6'b110010`, `6'b110110`, `6'b111010` and `6'b111110`. A recognised word with `in_slot` low gives `br_valid` = 1 on the next cycle.
- R3: `instr[29]` is the polarity. With 1 the branch is taken when the tested bit of `src_val` is 1. With 0 it is taken when that bit is 0.
- R4: The tested bit index is `{instr[28], instr[20:16]}`, so opcodes with `instr[28]` = 1 test bits 32 to 63.
- R5: When `br_valid` is 1, `br_target` equals PC + 4 + 4 × sign-extended `instr[15:0]`, taken modulo 2^64, whether or not the branch is taken.
- R6: `slot_follows` is 1 exactly when `br_valid` is 1, taken or not.
- R7: A recognised word with `in_slot` high gives `ri_excp` = 1 on the next cycle, with `br_valid`, `br_taken` and `slot_follows` all 0.
- R8: `br_taken` is never 1 without `br_valid`, and it appears in the same cycle as the matching `br_target`.
- R9: An unrecognised word has no effect: on the next cycle all four flags are 0, also when `in_slot` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Instruction word under decode |
| pc | input | 64 | Fetch address of `instr` |
| src_val | input | 64 | Value of the source register named by `instr[25:21]` |
| in_slot | input | 1 | `instr` occupies a delay or forbidden slot |
| br_valid | output | 1 | A bit-test branch was resolved |
| br_taken | output | 1 | The resolved branch is taken |
| br_target | output | 64 | Branch destination address |
| slot_follows | output | 1 | A single delay-slot word follows the branch |
| ri_excp | output | 1 | Reserved-instruction exception strobe |

## Verification
Two functions can fall on the same word: the taken decision and the delay-slot refusal. The bench presents recognised branches whose tested bit would make them taken while `in_slot` is high, in both polarities and both halves. It judges that the cycle carries only `ri_excp`, with no taken flag and no delay-slot indication. Target wrap-around is also made to coincide with a taken branch, by placing PCs near 2^64 and near 0 with forward and backward offsets. There the bench compares the target and the taken flag from the same sampled cycle.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;
  localparam int ILEN   = 32;
  localparam int OFFW   = 16;
  localparam int IDXW   = 6;

  typedef struct packed {
    logic            is_bbit;
    logic            sense;
    logic [IDXW-1:0] bit_idx;
    logic [OFFW-1:0] off;
  } bitbr_fields_t;
endpackage

// File: rtl/bitbr_decode.sv
module bitbr_decode
  import bitbr_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output bitbr_fields_t   fld
);
  logic hi_ok, lo_ok;
  assign hi_ok = (instr[31:30] == 2'b11);
  assign lo_ok = (instr[27:26] == 2'b10);

  always_comb begin
    fld.is_bbit = hi_ok && lo_ok;
    fld.sense   = instr[29];
    fld.bit_idx = {instr[28], instr[20:16]};
    fld.off     = instr[OFFW-1:0];
  end
endmodule

// File: rtl/bitbr_eval.sv
module bitbr_eval
  import bitbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  bitbr_fields_t   fld,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] src_val,
  output logic            take,
  output logic [XLEN-1:0] target
);
  localparam int EXTW = XLEN - OFFW - 2;

  function automatic logic [XLEN-1:0] calc_target(input logic [XLEN-1:0] p,
                                                  input logic [OFFW-1:0] o);
    logic [XLEN-1:0] disp;
    disp = {{EXTW{o[OFFW-1]}}, o, 2'b00};
    return p + XLEN'(4) + disp;
  endfunction

  function automatic logic bit_hit(input logic [XLEN-1:0] v,
                                   input logic [IDXW-1:0] idx,
                                   input logic            s);
    return v[idx] == s;
  endfunction

  assign take   = bit_hit(src_val, fld.bit_idx, fld.sense);
  assign target = calc_target(pc, fld.off);
endmodule

// File: rtl/bitbr_resolver.sv
module bitbr_resolver
  import bitbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] src_val,
  input  logic            in_slot,
  output logic            br_valid,
  output logic            br_taken,
  output logic [XLEN-1:0] br_target,
  output logic            slot_follows,
  output logic            ri_excp
);
  bitbr_fields_t   fld;
  logic            take_c;
  logic [XLEN-1:0] target_c;
  logic            dec_hit, slot_fault, go_branch;

  bitbr_decode u_dec (.instr(instr), .fld(fld));

  bitbr_eval #(.XLEN(XLEN)) u_eval (
    .fld(fld), .pc(pc), .src_val(src_val), .take(take_c), .target(target_c)
  );

  assign dec_hit    = fld.is_bbit;
  assign slot_fault = dec_hit && in_slot;
  assign go_branch  = dec_hit && !in_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_valid     <= 1'b0;
      br_taken     <= 1'b0;
      br_target    <= '0;
      slot_follows <= 1'b0;
      ri_excp      <= 1'b0;
    end else begin
      br_valid     <= go_branch;
      br_taken     <= go_branch && take_c;
      slot_follows <= go_branch;
      ri_excp      <= slot_fault;
      if (go_branch) br_target <= target_c;
    end
  end
endmodule

// File: rtl/bitbr_checker.sv
module bitbr_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] pc,
  input logic            in_slot,
  input logic            br_valid,
  input logic            br_taken,
  input logic [XLEN-1:0] br_target,
  input logic            slot_follows,
  input logic            ri_excp
);
  logic            is_family;
  logic [XLEN-1:0] prev_dest;

  assign is_family = (instr[31:26] == 6'b110010) || (instr[31:26] == 6'b110110) ||
                     (instr[31:26] == 6'b111010) || (instr[31:26] == 6'b111110);

  always_ff @(posedge clk) begin
    prev_dest <= pc + XLEN'(4) + XLEN'(signed'(instr[15:0])) * XLEN'(4);
  end

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ri_excp, br_valid}));
  assert_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_family && in_slot) |=> (ri_excp && !slot_follows));
  assert_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> br_valid);
  assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid == slot_follows);
  assert_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_family && !in_slot) |=> br_valid);
  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_family |=> (!br_valid && !ri_excp));
  assert_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> (br_target == prev_dest));
endmodule

bind bitbr_resolver bitbr_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .in_slot(in_slot),
  .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
  .slot_follows(slot_follows), .ri_excp(ri_excp)
);

// File: tb/tb_bitbr_resolver.sv
module tb_bitbr_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] pc = '0;
  logic [63:0] src_val = '0;
  logic        in_slot = 1'b0;
  logic        br_valid, br_taken, slot_follows, ri_excp;
  logic [63:0] br_target;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          v;
    bit          t;
    bit          ri;
    logic [63:0] tgt;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  bitbr_resolver dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .src_val(src_val),
    .in_slot(in_slot), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .slot_follows(slot_follows), .ri_excp(ri_excp)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [31:0] w, input logic [63:0] p,
                                 input logic [63:0] s, input bit slot, input string tag);
    exp_t e;
    bit fam;
    int idx;
    longint off;
    fam = w[31:26] inside {6'b110010, 6'b110110, 6'b111010, 6'b111110};
    idx = (w[28] ? 32 : 0) + int'(w[20:16]);
    off = longint'($signed(w[15:0]));
    e.v   = fam && !slot;
    e.ri  = fam && slot;
    e.t   = e.v && (((s >> idx) & 64'd1) == (w[29] ? 64'd1 : 64'd0));
    e.tgt = p + 64'd4 + 64'(off * 4);
    e.tag = tag;
    return e;
  endfunction

  task automatic compare_front();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk({e.tag, " R2 valid"}, 64'(br_valid), 64'(e.v));
    chk({e.tag, " R3 taken"}, 64'(br_taken), 64'(e.t));
    chk({e.tag, " R6 follows"}, 64'(slot_follows), 64'(e.v));
    chk({e.tag, " R7 ri"}, 64'(ri_excp), 64'(e.ri));
    // R8: target compared in the same sampled cycle as taken
    if (e.v) chk({e.tag, " R5 target"}, br_target, e.tgt);
  endtask

  task automatic step(input logic [31:0] w, input logic [63:0] p,
                      input logic [63:0] s, input bit slot, input string tag);
    @(negedge clk);
    compare_front();
    instr = w; pc = p; src_val = s; in_slot = slot;
    q.push_back(model(w, p, s, slot, tag));
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] lo,
                                     input logic [15:0] off);
    return {op, 5'd7, lo, off};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    instr = 32'hFFFF_FFFF; in_slot = 1'b1; src_val = '1; pc = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset valid", 64'(br_valid), 64'd0);
    chk("R1 reset taken", 64'(br_taken), 64'd0);
    chk("R1 reset follows", 64'(slot_follows), 64'd0);
    chk("R1 reset ri", 64'(ri_excp), 64'd0);
    chk("R1 reset target", br_target, 64'd0);
    rst_n = 1'b1;

    // R3/R4: low half, clear and set polarity
    step(mk(6'b110010, 5'd0, 16'd3), 64'h1000, 64'h0, 0, "R3 clr-bit0");
    step(mk(6'b110010, 5'd0, 16'd3), 64'h1000, 64'h1, 0, "R3 clr-bit0 nt");
    step(mk(6'b111010, 5'd31, 16'd8), 64'h2000, 64'h8000_0000, 0, "R4 set-bit31");
    step(mk(6'b111010, 5'd31, 16'd8), 64'h2000, 64'h1_0000_0000, 0, "R4 set-bit31 nt");
    // R4: high half boundary 32 and 63
    step(mk(6'b111110, 5'd0, 16'd1), 64'h3000, 64'h1_0000_0000, 0, "R4 set-bit32");
    step(mk(6'b111110, 5'd31, 16'd1), 64'h3000, 64'h8000_0000_0000_0000, 0, "R4 set-bit63");
    step(mk(6'b110110, 5'd31, 16'd1), 64'h3000, 64'h7FFF_FFFF_FFFF_FFFF, 0, "R4 clr-bit63");
    // R5: negative offset and wrap-around, coinciding with taken
    step(mk(6'b111010, 5'd2, 16'hFFFF), 64'h4000, 64'h4, 0, "R5 back");
    step(mk(6'b111010, 5'd2, 16'h8000), 64'h0, 64'h4, 0, "R5 wrap-low");
    step(mk(6'b110010, 5'd5, 16'h7FFF), 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 0, "R5 wrap-high");
    // R7: in slot with a would-be-taken branch
    step(mk(6'b111110, 5'd3, 16'd2), 64'h5000, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R7 slot set");
    step(mk(6'b110010, 5'd3, 16'd2), 64'h5000, 64'h0, 1, "R7 slot clr");
    // R9: unrecognised words, with and without in_slot
    step(mk(6'b110011, 5'd0, 16'd2), 64'h6000, 64'h0, 1, "R9 op110011");
    step(mk(6'b010010, 5'd0, 16'd2), 64'h6000, 64'h0, 0, "R9 op010010");
    step(mk(6'b111000, 5'd0, 16'd2), 64'h6000, 64'hFF, 1, "R9 op111000");
    step(mk(6'b111010, 5'd1, 16'd9), 64'h7000, 64'h2, 0, "R8 after");

    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      logic [31:0] w;
      if ($urandom % 4 == 0) op = 6'($urandom);
      else op = {2'b11, 1'($urandom), 1'($urandom), 2'b10};
      w = {op, 26'($urandom)};
      step(w, {32'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)},
           ($urandom % 5) == 0, "rand");
    end

    @(negedge clk);
    compare_front();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule